// File: doc/BRIEF.md
# Cell Port Controller with Header Label Translation

This block sits at one port of a fixed-slot cell switch and serves both directions of that port. On the way in, it collects each 53-byte cell from a byte-serial stream into a store that holds exactly one cell. It looks up the cell's 24-bit connection identifier in a small programmable associative table. On a hit, it sends the cell toward the fabric with one routing byte in front. The header of that cell carries the replacement identifier and a freshly computed header checksum. On a miss, the cell is discarded and a one-cycle miss flag is raised.

On the way out, the block takes tagged 54-byte cells from the fabric, drops the leading routing byte, and forwards exactly 53 bytes to the line side. Software or a control block fills the table through a plain address/data/write-enable port. Each entry holds a match key, a replacement identifier, a destination port number and a valid bit.

The header layout is as follows. Byte 0 is the 8-bit path part of the identifier. Bytes 1 and 2 are the 16-bit channel part, most significant byte first. Byte 3 is a control byte that passes through unchanged. Byte 4 is the header checksum. Bytes 5 to 52 are payload. A sender must leave at least one idle cycle between the final byte of a cell and the start of the next cell. Within a cell, gaps in `in_valid` are allowed.

Top module: `cell_port_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `fab_valid`, `fab_sop`, `lkup_miss`, `tx_valid` and `tx_sop` are 0 until traffic arrives.
- R2: A cell begins on a byte with `in_valid` and `in_sop` both high, and its next 52 bytes are the following cycles with `in_valid` high. A new `in_sop` before the 53rd byte abandons the partial cell and starts over. Bytes with `in_valid` high outside an open cell are ignored.
- R3: The lookup key is {byte0, byte1, byte2} of the received cell. Only entries with their valid bit set can match. When several entries match, the lowest table index wins.
- R4: If the final byte of a cell is sampled at clock edge E and the lookup hits, `fab_valid` is high for 54 consecutive cycles starting after edge E+1. `fab_sop` is high only with the first of those bytes, and `fab_valid` is low at all other times.
- R5: The first tagged byte carries the matched entry's port number in bits [PORT_W-1:0], with zeros above.
- R6: In tagged bytes 1 to 3, the header bytes 0 to 2 are replaced by the entry's new identifier, most significant byte first. Tagged byte 4 equals the received control byte, and tagged bytes 6 to 53 equal received bytes 5 to 52.
- R7: Tagged byte 5 is the CRC-8 (polynomial x^8+x^2+x+1, zero initial value, most significant bit first) over the rewritten header bytes 0 to 3, XORed with 0x55.
- R8: On a lookup miss, no tagged bytes are sent, and `lkup_miss` is high for exactly the one cycle after edge E+1.
- R9: A table write with `tbl_we` high stores key, new identifier, port and valid bit at `tbl_addr` on that edge. An entry written with valid 0 no longer matches, and later cells see the new contents.
- R10: On the fabric side, a byte with `fb_valid` and `fb_sop` both high is the routing byte and is dropped. The next 53 bytes with `fb_valid` high appear on `tx_data` one edge after being sampled, with `tx_sop` marking the first of them.
- R11: Fabric bytes beyond the 53rd, and fabric bytes arriving before any `fb_sop`, produce no output.
- R12: With one idle cycle between cells, the next cell is captured while the previous one is still being sent, and both come out intact and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Line-side byte valid |
| in_sop | input | 1 | First byte of a line-side cell |
| in_data | input | 8 | Line-side byte |
| tbl_we | input | 1 | Table entry write enable |
| tbl_addr | input | $clog2(TBL_DEPTH) | Table entry index |
| tbl_valid | input | 1 | Valid bit for the written entry |
| tbl_key | input | 24 | Identifier to match |
| tbl_new_id | input | 24 | Replacement identifier |
| tbl_port | input | PORT_W | Destination port number |
| fab_valid | output | 1 | Tagged byte toward fabric valid |
| fab_sop | output | 1 | Routing byte marker |
| fab_data | output | 8 | Tagged byte toward fabric |
| lkup_miss | output | 1 | One-cycle pulse for a dropped cell |
| fb_valid | input | 1 | Byte from fabric valid |
| fb_sop | input | 1 | Routing byte from fabric |
| fb_data | input | 8 | Byte from fabric |
| tx_valid | output | 1 | Line-side output byte valid |
| tx_sop | output | 1 | First byte of an outgoing cell |
| tx_data | output | 8 | Line-side output byte |

## Verification
Ingress results are timed from the edge E that samples a cell's final byte. The routing byte, or the miss pulse, is due after edge E+1, and tagged byte j is due after edge E+1+j. Egress bytes are due one edge after the fabric byte is sampled. The bench's reference model records each expected byte together with the exact cycle number it should appear in. On every falling edge it compares the ports against the entry due in that cycle, and in every other cycle it requires the valid and miss outputs to be idle. A byte that comes early, late or not at all therefore fails in the cycle where it goes wrong.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  localparam int unsigned ID_W = 24;
  localparam logic [7:0] CRC_POLY = 8'h07;
  localparam logic [7:0] POS_CTL = 8'd3;
  localparam logic [7:0] POS_HEC = 8'd4;

  typedef logic [ID_W-1:0] conn_id_t;

  // CRC-8 over a 32-bit header, MSB first, zero start, then coset XOR.
  function automatic logic [7:0] hec_calc(input logic [31:0] hdr,
                                          input logic [7:0] coset);
    logic [7:0] r;
    logic fb;
    r = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = r[7] ^ hdr[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r ^ coset;
  endfunction

  // Byte of the rewritten cell at position pos (0 = first header byte).
  function automatic logic [7:0] rewrite_byte(input logic [7:0] pos,
                                              input conn_id_t nid,
                                              input logic [7:0] hec,
                                              input logic [7:0] stored);
    case (pos)
      8'd0:    return nid[23:16];
      8'd1:    return nid[15:8];
      8'd2:    return nid[7:0];
      POS_HEC: return hec;
      default: return stored;
    endcase
  endfunction

endpackage

// File: rtl/cpc_cell_buf.sv
module cpc_cell_buf #(
  parameter int unsigned CELL_BYTES = 53,
  localparam int unsigned IDX_W = $clog2(CELL_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sop,
  input  logic [7:0]           in_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [7:0]           rd_data,
  output cpc_pkg::conn_id_t    hdr_id,
  output logic [7:0]           hdr_ctl,
  output logic                 cell_done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

  logic [7:0]       mem [CELL_BYTES];
  logic [IDX_W-1:0] wr_idx;
  logic             open_q;
  logic             take_first;
  logic             take_next;

  assign take_first = in_valid && in_sop;
  assign take_next  = in_valid && !in_sop && open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      wr_idx    <= '0;
      cell_done <= 1'b0;
    end else begin
      cell_done <= 1'b0;
      if (take_first) begin
        open_q <= 1'b1;
        wr_idx <= IDX_W'(1);
      end else if (take_next) begin
        wr_idx <= wr_idx + 1'b1;
        if (wr_idx == LAST) begin
          open_q    <= 1'b0;
          cell_done <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take_first)     mem[0] <= in_data;
    else if (take_next) mem[wr_idx] <= in_data;
  end

  assign rd_data = mem[rd_idx];
  assign hdr_id  = {mem[0], mem[1], mem[2]};
  assign hdr_ctl = mem[3];

endmodule

// File: rtl/cpc_label_table.sv
module cpc_label_table #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned PORT_W = 4,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic                wr_valid,
  input  cpc_pkg::conn_id_t   wr_key,
  input  cpc_pkg::conn_id_t   wr_new_id,
  input  logic [PORT_W-1:0]   wr_port,
  input  cpc_pkg::conn_id_t   lk_id,
  output logic                lk_hit,
  output cpc_pkg::conn_id_t   lk_new_id,
  output logic [PORT_W-1:0]   lk_port
);
  logic [DEPTH-1:0]   vld_q;
  cpc_pkg::conn_id_t  key_q  [DEPTH];
  cpc_pkg::conn_id_t  nid_q  [DEPTH];
  logic [PORT_W-1:0]  port_q [DEPTH];
  logic [DEPTH-1:0]   match;
  logic [AW-1:0]      sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_addr] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_q[wr_addr]  <= wr_key;
      nid_q[wr_addr]  <= wr_new_id;
      port_q[wr_addr] <= wr_port;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (key_q[g] == lk_id);
  end

  // Scan downward so the lowest matching index is the last one kept.
  always_comb begin
    sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) sel = AW'(i);
    end
  end

  assign lk_hit    = |match;
  assign lk_new_id = nid_q[sel];
  assign lk_port   = port_q[sel];

endmodule

// File: rtl/cpc_tag_emit.sv
module cpc_tag_emit #(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned PORT_W     = 4,
  parameter logic [7:0]  HEC_COSET  = 8'h55,
  localparam int unsigned IDX_W = $clog2(CELL_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                hit,
  input  cpc_pkg::conn_id_t   new_id,
  input  logic [PORT_W-1:0]   port,
  input  logic [7:0]          ctl,
  input  logic [7:0]          rd_data,
  output logic [IDX_W-1:0]    rd_idx,
  output logic                fab_valid,
  output logic                fab_sop,
  output logic [7:0]          fab_data,
  output logic                miss
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

  logic              busy_q;
  logic [IDX_W-1:0]  pos_q;
  cpc_pkg::conn_id_t nid_q;
  logic [7:0]        hec_q;

  assign rd_idx = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      pos_q     <= '0;
      nid_q     <= '0;
      hec_q     <= '0;
      fab_valid <= 1'b0;
      fab_sop   <= 1'b0;
      fab_data  <= '0;
      miss      <= 1'b0;
    end else begin
      miss <= start && !hit;
      if (start && hit) begin
        busy_q    <= 1'b1;
        pos_q     <= '0;
        nid_q     <= new_id;
        hec_q     <= cpc_pkg::hec_calc({new_id, ctl}, HEC_COSET);
        fab_valid <= 1'b1;
        fab_sop   <= 1'b1;
        fab_data  <= 8'(port);
      end else if (busy_q) begin
        fab_valid <= 1'b1;
        fab_sop   <= 1'b0;
        fab_data  <= cpc_pkg::rewrite_byte(8'(pos_q), nid_q, hec_q, rd_data);
        pos_q     <= pos_q + 1'b1;
        if (pos_q == LAST) busy_q <= 1'b0;
      end else begin
        fab_valid <= 1'b0;
        fab_sop   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cpc_tag_strip.sv
module cpc_tag_strip #(
  parameter int unsigned CELL_BYTES = 53,
  localparam int unsigned REM_W = $clog2(CELL_BYTES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_valid,
  input  logic       fb_sop,
  input  logic [7:0] fb_data,
  output logic       tx_valid,
  output logic       tx_sop,
  output logic [7:0] tx_data
);
  localparam logic [REM_W-1:0] FULL = REM_W'(CELL_BYTES);

  logic [REM_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      tx_valid <= 1'b0;
      tx_sop   <= 1'b0;
      tx_data  <= '0;
    end else if (fb_valid && fb_sop) begin
      rem_q    <= FULL;
      tx_valid <= 1'b0;
      tx_sop   <= 1'b0;
    end else if (fb_valid && rem_q != '0) begin
      rem_q    <= rem_q - 1'b1;
      tx_valid <= 1'b1;
      tx_sop   <= (rem_q == FULL);
      tx_data  <= fb_data;
    end else begin
      tx_valid <= 1'b0;
      tx_sop   <= 1'b0;
    end
  end

endmodule

// File: rtl/cell_port_ctrl.sv
module cell_port_ctrl #(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned TBL_DEPTH  = 16,
  parameter int unsigned PORT_W     = 4,
  parameter logic [7:0]  HEC_COSET  = 8'h55,
  localparam int unsigned AW    = $clog2(TBL_DEPTH),
  localparam int unsigned IDX_W = $clog2(CELL_BYTES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_sop,
  input  logic [7:0]                in_data,
  input  logic                      tbl_we,
  input  logic [AW-1:0]             tbl_addr,
  input  logic                      tbl_valid,
  input  logic [cpc_pkg::ID_W-1:0]  tbl_key,
  input  logic [cpc_pkg::ID_W-1:0]  tbl_new_id,
  input  logic [PORT_W-1:0]         tbl_port,
  output logic                      fab_valid,
  output logic                      fab_sop,
  output logic [7:0]                fab_data,
  output logic                      lkup_miss,
  input  logic                      fb_valid,
  input  logic                      fb_sop,
  input  logic [7:0]                fb_data,
  output logic                      tx_valid,
  output logic                      tx_sop,
  output logic [7:0]                tx_data
);
  // Named internal events used by the checker.
  logic               cell_done;
  logic               lk_hit;
  cpc_pkg::conn_id_t  hdr_id;
  logic [7:0]         hdr_ctl;
  cpc_pkg::conn_id_t  lk_new_id;
  logic [PORT_W-1:0]  lk_port;
  logic [IDX_W-1:0]   rd_idx;
  logic [7:0]         rd_data;

  cpc_cell_buf #(.CELL_BYTES(CELL_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .hdr_id(hdr_id), .hdr_ctl(hdr_ctl), .cell_done(cell_done)
  );

  cpc_label_table #(.DEPTH(TBL_DEPTH), .PORT_W(PORT_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_valid(tbl_valid),
    .wr_key(tbl_key), .wr_new_id(tbl_new_id), .wr_port(tbl_port),
    .lk_id(hdr_id), .lk_hit(lk_hit), .lk_new_id(lk_new_id), .lk_port(lk_port)
  );

  cpc_tag_emit #(.CELL_BYTES(CELL_BYTES), .PORT_W(PORT_W), .HEC_COSET(HEC_COSET)) u_emit (
    .clk(clk), .rst_n(rst_n),
    .start(cell_done), .hit(lk_hit), .new_id(lk_new_id), .port(lk_port),
    .ctl(hdr_ctl), .rd_data(rd_data), .rd_idx(rd_idx),
    .fab_valid(fab_valid), .fab_sop(fab_sop), .fab_data(fab_data), .miss(lkup_miss)
  );

  cpc_tag_strip #(.CELL_BYTES(CELL_BYTES)) u_strip (
    .clk(clk), .rst_n(rst_n),
    .fb_valid(fb_valid), .fb_sop(fb_sop), .fb_data(fb_data),
    .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_data(tx_data)
  );

endmodule

// File: rtl/cell_port_ctrl_chk.sv
module cell_port_ctrl_chk #(
  parameter int unsigned PORT_W = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       cell_done,
  input logic       lk_hit,
  input logic       fab_valid,
  input logic       fab_sop,
  input logic [7:0] fab_data,
  input logic       lkup_miss,
  input logic       fb_valid,
  input logic       tx_valid,
  input logic       tx_sop
);

  p_done_on_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cell_done |-> $past(in_valid));

  p_sop_has_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fab_sop |-> fab_valid);

  p_launch_after_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fab_sop |-> $past(cell_done && lk_hit));

  p_tag_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fab_sop |-> ((fab_data >> PORT_W) == 8'h00));

  p_miss_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lkup_miss |-> $past(cell_done && !lk_hit));

  p_miss_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lkup_miss |=> !lkup_miss);

  p_miss_no_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lkup_miss |-> !fab_sop);

  p_tx_from_fabric_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(fb_valid));

  p_tx_sop_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sop |-> tx_valid);

endmodule

bind cell_port_ctrl cell_port_ctrl_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .cell_done(cell_done), .lk_hit(lk_hit),
  .fab_valid(fab_valid), .fab_sop(fab_sop), .fab_data(fab_data),
  .lkup_miss(lkup_miss), .fb_valid(fb_valid),
  .tx_valid(tx_valid), .tx_sop(tx_sop)
);

// File: tb/cell_port_ctrl_tb.sv
`timescale 1ns/1ps
module cell_port_ctrl_tb;
  localparam int CELL = 53;
  localparam int PW   = 4;
  localparam int DEP  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0;
  logic [7:0] in_data = 0;
  logic tbl_we = 0, tbl_valid = 0;
  logic [3:0] tbl_addr = 0;
  logic [23:0] tbl_key = 0, tbl_new_id = 0;
  logic [PW-1:0] tbl_port = 0;
  logic fab_valid, fab_sop, lkup_miss, tx_valid, tx_sop;
  logic [7:0] fab_data, tx_data;
  logic fb_valid = 0, fb_sop = 0;
  logic [7:0] fb_data = 0;

  cell_port_ctrl #(.CELL_BYTES(CELL), .TBL_DEPTH(DEP), .PORT_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_valid(tbl_valid), .tbl_key(tbl_key),
    .tbl_new_id(tbl_new_id), .tbl_port(tbl_port),
    .fab_valid(fab_valid), .fab_sop(fab_sop), .fab_data(fab_data), .lkup_miss(lkup_miss),
    .fb_valid(fb_valid), .fb_sop(fb_sop), .fb_data(fb_data),
    .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_data(tx_data)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; logic sop; logic [7:0] d; string req; } exp_t;
  exp_t fq[$];
  exp_t tq[$];
  int   mq[$];

  bit          mv [DEP];
  logic [23:0] mk [DEP];
  logic [23:0] mn [DEP];
  logic [PW-1:0] mp [DEP];

  int n_run = 0, n_fail = 0;
  bit chk_on = 0;
  bit finished = 0;
  int fb_rem = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_hec(logic [31:0] h);
    logic [39:0] v;
    v = {h, 8'h00};
    for (int i = 39; i >= 8; i--) if (v[i]) v[i -: 9] = v[i -: 9] ^ 9'h107;
    return v[7:0] ^ 8'h55;
  endfunction

  // Per-cycle comparison against the reference queues.
  always @(negedge clk) if (chk_on) begin
    if (fq.size() > 0 && fq[0].at == cyc) begin
      exp_t e;
      e = fq.pop_front();
      check(e.req, "fabric byte", 32'({fab_valid, fab_sop, fab_data}), 32'({1'b1, e.sop, e.d}));
    end else begin
      check("R4", "fabric idle", 32'(fab_valid), 32'(0));
    end
    if (mq.size() > 0 && mq[0] == cyc) begin
      void'(mq.pop_front());
      check("R8", "miss pulse", 32'(lkup_miss), 32'(1));
    end else begin
      check("R8", "miss quiet", 32'(lkup_miss), 32'(0));
    end
    if (tq.size() > 0 && tq[0].at == cyc) begin
      exp_t e;
      e = tq.pop_front();
      check(e.req, "line byte", 32'({tx_valid, tx_sop, tx_data}), 32'({1'b1, e.sop, e.d}));
    end else begin
      check("R11", "line idle", 32'(tx_valid), 32'(0));
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_sop = 0; fb_valid = 0; fb_sop = 0;
    end
  endtask

  task automatic tbl_write(int a, bit v, logic [23:0] k, logic [23:0] n, logic [PW-1:0] p);
    @(negedge clk);
    tbl_we = 1; tbl_addr = 4'(a); tbl_valid = v; tbl_key = k; tbl_new_id = n; tbl_port = p;
    mv[a] = v; mk[a] = k; mn[a] = n; mp[a] = p;
    @(negedge clk);
    tbl_we = 0;
  endtask

  // Drives one full cell; gap_at inserts an idle cycle before that byte.
  task automatic send_cell(logic [23:0] id, logic [7:0] ctl, int seed, int gap_at, string req);
    logic [7:0] b [CELL];
    logic [7:0] hb;
    int last, hit;
    b[0] = id[23:16]; b[1] = id[15:8]; b[2] = id[7:0]; b[3] = ctl;
    b[4] = 8'(seed) ^ 8'hA5;
    for (int i = 5; i < CELL; i++) b[i] = 8'(seed * 7 + i * 13);
    for (int i = 0; i < CELL; i++) begin
      if (i == gap_at) begin
        @(negedge clk);
        in_valid = 0; in_sop = 0;
      end
      @(negedge clk);
      in_valid = 1; in_sop = (i == 0); in_data = b[i];
    end
    last = cyc + 1;
    @(negedge clk);
    in_valid = 0; in_sop = 0;
    hit = -1;
    for (int i = 0; i < DEP; i++) if (hit < 0 && mv[i] && mk[i] == id) hit = i;
    if (hit < 0) begin
      mq.push_back(last + 1);
    end else begin
      fq.push_back('{last + 1, 1'b1, 8'(mp[hit]), req});
      for (int j = 0; j < CELL; j++) begin
        if (j < 3)       hb = 8'(mn[hit] >> (8 * (2 - j)));
        else if (j == 3) hb = ctl;
        else if (j == 4) hb = ref_hec({mn[hit], ctl});
        else             hb = b[j];
        fq.push_back('{last + 2 + j, 1'b0, hb, (j == 4) ? "R7" : "R6"});
      end
    end
  endtask

  task automatic fab_byte(bit v, bit s, logic [7:0] d);
    @(negedge clk);
    fb_valid = v; fb_sop = s; fb_data = d;
    if (v && s) fb_rem = CELL;
    else if (v && fb_rem > 0) begin
      tq.push_back('{cyc + 1, (fb_rem == CELL), d, "R10"});
      fb_rem--;
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet in reset and just after release
    repeat (3) @(negedge clk);
    check("R1", "reset outputs", 32'({fab_valid, fab_sop, lkup_miss, tx_valid, tx_sop}), 32'(0));
    rst_n = 1;
    @(negedge clk);
    check("R1", "post-reset outputs", 32'({fab_valid, fab_sop, lkup_miss, tx_valid, tx_sop}), 32'(0));
    chk_on = 1;

    tbl_write(0, 1, 24'h12_3456, 24'hAB_CDEF, 4'd3);
    tbl_write(1, 1, 24'h01_0002, 24'h7F_0001, 4'd9);
    tbl_write(5, 1, 24'hFF_FFFF, 24'h00_0000, 4'd15);
    tbl_write(7, 1, 24'h44_5566, 24'h11_2233, 4'd2);   // R3 lower index
    tbl_write(9, 1, 24'h44_5566, 24'h99_8877, 4'd6);   // R3 shadowed

    send_cell(24'h12_3456, 8'h3C, 1, -1, "R5");  idle(60);
    send_cell(24'hFF_FFFF, 8'h00, 2, 20, "R5");  idle(60);  // R2 pause mid-cell
    send_cell(24'h44_5566, 8'h81, 3, -1, "R3");  idle(60);
    send_cell(24'hDE_AD00, 8'h11, 4, -1, "R8");  idle(60);  // miss

    // R12: back-to-back with one idle cycle
    send_cell(24'h01_0002, 8'h5A, 5, -1, "R12");
    send_cell(24'h12_3456, 8'hC3, 6, -1, "R12");
    send_cell(24'h01_0002, 8'h0F, 7, -1, "R12");
    idle(80);

    // R2: stray bytes with no open cell produce nothing
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1; in_sop = 0; in_data = 8'(i);
    end
    idle(60);

    // R2: restart by a new start before the cell completes
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (i == 0); in_data = (i == 0) ? 8'h12 : 8'(i);
    end
    send_cell(24'h01_0002, 8'h77, 8, -1, "R2");
    idle(60);

    // R9: invalidate, then rewrite with new contents
    tbl_write(0, 0, 24'h12_3456, 24'hAB_CDEF, 4'd3);
    send_cell(24'h12_3456, 8'h22, 9, -1, "R9");  idle(60);
    tbl_write(0, 1, 24'h12_3456, 24'h55_AA55, 4'd12);
    send_cell(24'h12_3456, 8'h22, 10, -1, "R9"); idle(60);
    tbl_write(7, 0, 24'h44_5566, 24'h11_2233, 4'd2);
    send_cell(24'h44_5566, 8'h90, 11, -1, "R3"); idle(60);

    // Egress: R11 leading strays, R10 strip, R11 trailing extras
    fab_byte(1, 0, 8'hEE); fab_byte(1, 0, 8'hEF);
    fab_byte(1, 1, 8'h03);
    for (int i = 0; i < CELL; i++) fab_byte(1, 0, 8'(i * 5 + 1));
    for (int i = 0; i < 3; i++) fab_byte(1, 0, 8'hF0);
    idle(4);
    fab_byte(1, 1, 8'h0A);
    for (int i = 0; i < CELL; i++) begin
      if (i % 9 == 4) fab_byte(0, 0, 8'h00);
      fab_byte(1, 0, 8'(255 - i));
    end
    fab_byte(1, 1, 8'h01);
    fab_byte(1, 0, 8'h42);
    idle(80);

    check("R4", "pending fabric bytes", 32'(fq.size()), 32'(0));
    check("R10", "pending line bytes", 32'(tq.size()), 32'(0));
    check("R8", "pending miss pulses", 32'(mq.size()), 32'(0));
    finished = 1;
    summary();
    $finish;
  end

endmodule